// File: doc/BRIEF.md
# Read Training Pattern Generator

This block sits on the memory-device side of a DQ interface and answers read-training requests with a known, deterministic burst of sixteen beats spread across a parameterised set of data lanes (eight by default). A host uses these bursts to centre its receive strobes and reference voltage. The bursts carry no array data; the block only generates a pattern.

A small configuration file is loaded through a one-cycle register-write port. It holds two pattern bytes, a per-lane inversion mask, a per-lane generator-select mask and a pattern-type field. Three pattern types are offered:

- a programmable serial pattern built from the two bytes;
- a toggling clock pattern;
- a pseudo-random pattern from two 8-bit LFSRs.

In pseudo-random mode the two bytes act as the LFSR seeds. Each lane takes one of the two generators and may be inverted, so neighbouring lanes can carry different sequences and exercise lane-to-lane crosstalk.

The controller is a two-state machine. Its states are `ST_IDLE` (no burst) and `ST_BURST` (beats 0 to 15 being driven). It has four named transitions:

- *start*: `ST_IDLE` to `ST_BURST`, when a request is sampled.
- *advance*: `ST_BURST` to `ST_BURST`, on beats 0 to 14.
- *restart*: `ST_BURST` to `ST_BURST`, on beat 15 when a request is queued or arrives.
- *finish*: `ST_BURST` to `ST_IDLE`, on beat 15 with no request.

A row-activate command seen during a burst is ignored and latches a sticky error flag.

Top module: `rtp_gen`

## Requirements
- R1: A request sampled high at a clock edge while idle makes beat 0 appear right after that edge. The burst then runs 16 consecutive cycles with `dq_valid` high, and `dq_last` is high only on beat 15. While `dq_valid` is low, `dq_out` is all zero.
- R2: The write port register addresses are: 0 = pattern/seed byte A, 1 = pattern/seed byte B, 2 = inversion mask, 3 = generator-select mask, 4 = pattern type. The pattern type is held in data bits 1:0: 00 = serial, 01 = clock, 1x = pseudo-random.
- R3: In serial mode, every lane sends byte A bits 7 down to 0 on beats 0 to 7, then byte B bits 7 down to 0 on beats 8 to 15.
- R4: In clock mode, every lane sends 0 on even beats and 1 on odd beats.
- R5: Pseudo-random generation:
  - Each generator is an 8-bit Fibonacci LFSR with polynomial x^8+x^6+x^5+x^4+1. Its next state is {s[6:0], s[7]^s[5]^s[4]^s[3]}.
  - Each beat outputs the current bit 7, and the state then advances once per beat. Generators advance only during pseudo-random bursts.
  - Lane i uses generator B when select-mask bit i is 1, and generator A otherwise.
- R6: Lane i is inverted when inversion-mask bit i is 1, in every pattern type.
- R7: Writing byte A or byte B reloads the matching generator from the written value. A written value of zero loads 8'h01 instead.
- R8: Generator state carries over between bursts, so a following pseudo-random burst continues the sequence.
- R9: A request arriving during a burst is held, one deep, and its burst begins the cycle after beat 15. A request on beat 15 itself also restarts at once. Further requests while one is already held are dropped.
- R10: A row-activate command during a burst does not disturb it and sets the sticky `act_err` flag. An activate while idle leaves the flag unchanged.
- R11: Register writes sampled during a burst are discarded.
- R12: After reset the outputs are quiet and `act_err` is 0. Both bytes, both masks and the pattern type (serial) are zero, and both generators hold 8'h01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | REG_W (8) | Register write data |
| rd_req | input | 1 | Read-training request |
| act_cmd | input | 1 | Row-activate command seen by the device |
| dq_out | output | LANES (8) | Pattern beat, one bit per lane |
| dq_valid | output | 1 | Beat on `dq_out` is valid |
| dq_last | output | 1 | Final beat of a burst |
| act_err | output | 1 | Sticky flag: activate arrived during a burst |

## Verification
The hardest conditions to reach are request timing against the burst boundary. These are a request held mid-burst, a third request that must be dropped while one is already held, and a request placed exactly on beat 15. The stimulus counts clock edges from the sampled request to place each pulse on a chosen beat. The scoreboard marks the first beat of each follow-on burst and requires the previous cycle to have been a final beat. Because generator state carries over, the expected sequence of the follow-on burst depends on the bursts before it. Any beat without a matching expected item is reported as a failure.

// File: rtl/rtp_pkg.sv
package rtp_pkg;

    localparam int LFSR_W = 8;
    localparam int BEATS  = 2 * LFSR_W;
    localparam int BEAT_W = $clog2(BEATS);
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_PAT0 = 3'd0;
    localparam logic [ADDR_W-1:0] A_PAT1 = 3'd1;
    localparam logic [ADDR_W-1:0] A_INV  = 3'd2;
    localparam logic [ADDR_W-1:0] A_SEL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd4;

    typedef enum logic [1:0] {
        PAT_SERIAL   = 2'b00,
        PAT_CLOCK    = 2'b01,
        PAT_PRBS     = 2'b10,
        PAT_PRBS_ALT = 2'b11
    } pat_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } gen_state_e;

    // x^8 + x^6 + x^5 + x^4 + 1, shift toward the MSB
    function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic [LFSR_W-1:0] seed_guard(input logic [LFSR_W-1:0] s);
        return (s == '0) ? LFSR_W'(1) : s;
    endfunction

endpackage

// File: rtl/rtp_regs.sv
module rtp_regs
    import rtp_pkg::*;
#(
    parameter int LANES = 8,
    parameter int REG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              busy,
    output logic [LFSR_W-1:0] pat_a,
    output logic [LFSR_W-1:0] pat_b,
    output logic [LANES-1:0]  inv_mask,
    output logic [LANES-1:0]  sel_mask,
    output pat_mode_e         mode,
    output logic [1:0]        seed_ld,
    output logic [LFSR_W-1:0] seed_val
);

    logic              wr_ok;
    logic [LFSR_W-1:0] pat_q [2];

    assign wr_ok    = wr_en && !busy;
    assign seed_val = seed_guard(wdata[LFSR_W-1:0]);

    for (genvar g = 0; g < 2; g++) begin : g_pat
        localparam logic [ADDR_W-1:0] MY_ADDR = A_PAT0 + ADDR_W'(g);

        assign seed_ld[g] = wr_ok && (addr == MY_ADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pat_q[g] <= '0;
            else if (seed_ld[g]) pat_q[g] <= wdata[LFSR_W-1:0];
        end
    end

    assign pat_a = pat_q[0];
    assign pat_b = pat_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_mask <= '0;
            sel_mask <= '0;
            mode     <= PAT_SERIAL;
        end else if (wr_ok) begin
            if (addr == A_INV)  inv_mask <= wdata[LANES-1:0];
            if (addr == A_SEL)  sel_mask <= wdata[LANES-1:0];
            if (addr == A_MODE) mode     <= pat_mode_e'(wdata[1:0]);
        end
    end

endmodule

// File: rtl/rtp_lfsr.sv
module rtp_lfsr
    import rtp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LFSR_W-1:0] load_val,
    input  logic              step,
    output logic [LFSR_W-1:0] state
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state <= LFSR_W'(1);
        else if (load) state <= load_val;
        else if (step) state <= lfsr_advance(state);
    end

endmodule

// File: rtl/rtp_ctrl.sv
module rtp_ctrl
    import rtp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              act_cmd,
    output logic              busy,
    output logic              last,
    output logic [BEAT_W-1:0] beat,
    output logic              pending,
    output logic              act_err
);

    gen_state_e        state_q, state_d;
    logic [BEAT_W-1:0] beat_q;
    logic              pend_q;
    logic              err_q;
    logic              at_last;

    assign at_last = (state_q == ST_BURST) && (beat_q == BEAT_W'(BEATS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: start, advance, restart, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_req) state_d = ST_BURST;
            end
            ST_BURST: begin
                if (at_last && !(pend_q || rd_req)) state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
            pend_q <= 1'b0;
        end else if (state_q == ST_BURST) begin
            beat_q <= at_last ? '0 : beat_q + 1'b1;
            pend_q <= at_last ? (pend_q && rd_req) : (pend_q || rd_req);
        end else begin
            beat_q <= '0;
            pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                err_q <= 1'b0;
        else if (state_q == ST_BURST && act_cmd)   err_q <= 1'b1;
    end

    // outputs
    always_comb begin
        busy    = (state_q == ST_BURST);
        last    = at_last;
        beat    = beat_q;
        pending = pend_q;
        act_err = err_q;
    end

endmodule

// File: rtl/rtp_lanes.sv
module rtp_lanes
    import rtp_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic              active,
    input  pat_mode_e         mode,
    input  logic [BEAT_W-1:0] beat,
    input  logic [BEATS-1:0]  pat_word,
    input  logic [LANES-1:0]  inv_mask,
    input  logic [LANES-1:0]  sel_mask,
    input  logic [1:0]        prbs_bit,
    output logic [LANES-1:0]  dq
);

    logic [BEAT_W-1:0] ser_idx;
    logic              ser_bit;
    logic              clk_bit;

    always_comb begin
        ser_idx = BEAT_W'(BEATS - 1) - beat;
        ser_bit = pat_word[ser_idx];
        clk_bit = beat[0];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic raw;
        always_comb begin
            unique case (mode)
                PAT_SERIAL:             raw = ser_bit;
                PAT_CLOCK:              raw = clk_bit;
                PAT_PRBS, PAT_PRBS_ALT: raw = prbs_bit[sel_mask[i]];
            endcase
            dq[i] = active & (raw ^ inv_mask[i]);
        end
    end

endmodule

// File: rtl/rtp_gen.sv
module rtp_gen
    import rtp_pkg::*;
#(
    parameter int LANES = 8,
    parameter int REG_W = (LANES > LFSR_W) ? LANES : LFSR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              rd_req,
    input  logic              act_cmd,
    output logic [LANES-1:0]  dq_out,
    output logic              dq_valid,
    output logic              dq_last,
    output logic              act_err
);

    logic              busy_w;
    logic              last_w;
    logic [BEAT_W-1:0] beat_w;
    logic              pend_w;
    logic [LFSR_W-1:0] pat_a, pat_b;
    logic [LANES-1:0]  inv_w, sel_w;
    pat_mode_e         mode_w;
    logic [1:0]        seed_ld;
    logic [LFSR_W-1:0] seed_val;
    logic [LFSR_W-1:0] lfsr_st [2];
    logic [1:0]        prbs_bit;
    logic              prbs_step;

    rtp_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .act_cmd (act_cmd),
        .busy    (busy_w),
        .last    (last_w),
        .beat    (beat_w),
        .pending (pend_w),
        .act_err (act_err)
    );

    rtp_regs #(.LANES(LANES), .REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .busy     (busy_w),
        .pat_a    (pat_a),
        .pat_b    (pat_b),
        .inv_mask (inv_w),
        .sel_mask (sel_w),
        .mode     (mode_w),
        .seed_ld  (seed_ld),
        .seed_val (seed_val)
    );

    assign prbs_step = busy_w && mode_w[1];

    for (genvar g = 0; g < 2; g++) begin : g_gen
        rtp_lfsr u_lfsr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (seed_ld[g]),
            .load_val (seed_val),
            .step     (prbs_step),
            .state    (lfsr_st[g])
        );
        assign prbs_bit[g] = lfsr_st[g][LFSR_W-1];
    end

    rtp_lanes #(.LANES(LANES)) u_lanes (
        .active   (busy_w),
        .mode     (mode_w),
        .beat     (beat_w),
        .pat_word ({pat_a, pat_b}),
        .inv_mask (inv_w),
        .sel_mask (sel_w),
        .prbs_bit (prbs_bit),
        .dq       (dq_out)
    );

    assign dq_valid = busy_w;
    assign dq_last  = last_w;

endmodule

// File: rtl/rtp_gen_chk.sv
module rtp_gen_chk
    import rtp_pkg::*;
#(
    parameter int LANES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              act_cmd,
    input logic              dq_valid,
    input logic              dq_last,
    input logic [LANES-1:0]  dq_out,
    input logic              act_err,
    input logic [BEAT_W-1:0] beat,
    input logic              pending
);

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dq_valid && rd_req) |=> (dq_valid && beat == '0)); // R1

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && !dq_last) |=> (dq_valid && beat == BEAT_W'($past(beat) + 1'b1))); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_valid |-> (dq_out == '0)); // R1

    AST_QUEUE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_last && pending) |=> (dq_valid && beat == '0)); // R9

    AST_PENDING_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> dq_valid); // R9

    AST_ACT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && !dq_last && act_cmd) |=> dq_valid); // R10

    AST_ACT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && act_cmd) |=> act_err); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        act_err |=> act_err); // R10

endmodule

bind rtp_gen rtp_gen_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .act_cmd  (act_cmd),
    .dq_valid (dq_valid),
    .dq_last  (dq_last),
    .dq_out   (dq_out),
    .act_err  (act_err),
    .beat     (beat_w),
    .pending  (pend_w)
);

// File: tb/sim_rtp_gen.sv
module sim_rtp_gen;

    localparam int LANES = 8;
    localparam int REG_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr_en = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic             rd_req = 1'b0;
    logic             act_cmd = 1'b0;
    logic [LANES-1:0] dq_out;
    logic             dq_valid;
    logic             dq_last;
    logic             act_err;

    int n_tests = 0;
    int n_fail  = 0;
    int n_unexp = 0;
    bit done    = 0;
    bit prev_last = 0;

    always #10 clk = ~clk;

    rtp_gen #(.LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_req(rd_req), .act_cmd(act_cmd),
        .dq_out(dq_out), .dq_valid(dq_valid), .dq_last(dq_last), .act_err(act_err)
    );

    // scoreboard queues
    logic [LANES-1:0] q_d[$];
    bit               q_last[$];
    bit               q_contig[$];
    string            q_tag[$];

    // bench model of the configuration
    logic [7:0]       m_a = 8'h00, m_b = 8'h00, m_l0 = 8'h01, m_l1 = 8'h01;
    logic [LANES-1:0] m_inv = '0, m_sel = '0;
    logic [1:0]       m_mode = 2'b00;

    function automatic logic [7:0] nxt(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_burst(input string tag, input bit contig);
        for (int b = 0; b < 16; b++) begin
            logic [LANES-1:0] w;
            logic [15:0] pw;
            pw = {m_a, m_b};
            for (int i = 0; i < LANES; i++) begin
                logic r;
                if (m_mode == 2'b00)      r = pw[15-b];
                else if (m_mode == 2'b01) r = b[0];
                else                      r = m_sel[i] ? m_l1[7] : m_l0[7];
                w[i] = r ^ m_inv[i];
            end
            q_d.push_back(w);
            q_last.push_back(b == 15);
            q_contig.push_back(contig && b == 0);
            q_tag.push_back(tag);
            if (m_mode[1]) begin
                m_l0 = nxt(m_l0);
                m_l1 = nxt(m_l1);
            end
        end
    endtask

    task automatic req_pulse();
        @(posedge clk); #2 rd_req = 1'b1;
        @(posedge clk); #2 rd_req = 1'b0;
    endtask

    task automatic act_pulse();
        @(posedge clk); #2 act_cmd = 1'b1;
        @(posedge clk); #2 act_cmd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit applies);
        @(posedge clk); #2 reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2 reg_wr_en = 1'b0;
        if (applies) begin
            case (a)
                3'd0: begin m_a = d; m_l0 = (d == 0) ? 8'h01 : d; end
                3'd1: begin m_b = d; m_l1 = (d == 0) ? 8'h01 : d; end
                3'd2: m_inv = d;
                3'd3: m_sel = d;
                3'd4: m_mode = d[1:0];
                default: ;
            endcase
        end
    endtask

    task automatic drain();
        while (q_d.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (dq_valid) begin
                if (q_d.size() == 0) begin
                    n_unexp++;
                    check(0, "R9 beat with no expected burst", dq_out, 0);
                end else begin
                    logic [LANES-1:0] e;
                    bit el, ec;
                    string t;
                    e = q_d.pop_front(); el = q_last.pop_front();
                    ec = q_contig.pop_front(); t = q_tag.pop_front();
                    check(dq_out == e, t, dq_out, e);
                    check(dq_last == el, "R1 last-beat marker", dq_last, el);
                    if (ec) check(prev_last, "R9 follow-on burst not adjacent", prev_last, 1);
                end
            end else begin
                check(dq_out == '0 && !dq_last, "R1 idle outputs quiet", dq_out, 0);
            end
            prev_last = dq_valid && dq_last;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            check(0, "watchdog expired", 0, 1);
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(!dq_valid && dq_out == '0 && !act_err, "R12 reset outputs", {dq_valid, act_err}, 0);

        // R12: default registers give an all-zero serial burst
        push_burst("R12 default serial burst", 0); req_pulse(); drain();

        // R2 R3: serial pattern
        wr(3'd0, 8'hA5, 1); wr(3'd1, 8'h3C, 1);
        push_burst("R3 serial A5/3C", 0); req_pulse(); drain();

        // R6: inversion in serial mode
        wr(3'd2, 8'h0F, 1);
        push_burst("R6 serial with inversion", 0); req_pulse(); drain();

        // R4 R6: clock pattern
        wr(3'd4, 8'h01, 1); wr(3'd2, 8'hA0, 1);
        push_burst("R4 clock with inversion", 0); req_pulse(); drain();

        // R5 R7: pseudo-random, zero seed substituted
        wr(3'd2, 8'h00, 1); wr(3'd0, 8'h00, 1); wr(3'd1, 8'hB7, 1);
        wr(3'd3, 8'h55, 1); wr(3'd4, 8'h02, 1);
        push_burst("R5 prbs per-lane select", 0); req_pulse();
        // R9 R8: held request mid-burst, continues the sequence; a third is dropped
        repeat (4) @(posedge clk);
        push_burst("R8 prbs continuation after held request", 1); req_pulse();
        repeat (2) @(posedge clk);
        req_pulse();
        drain();
        check(n_unexp == 0, "R9 extra request dropped", n_unexp, 0);

        // R9: request on the final beat restarts immediately
        wr(3'd2, 8'h3C, 1);
        push_burst("R6 prbs with inversion", 0); req_pulse();
        repeat (14) @(posedge clk);
        push_burst("R9 restart on final beat", 1); req_pulse();
        drain();

        // R7: reseed reloads generator
        wr(3'd0, 8'h5E, 1); wr(3'd2, 8'h00, 1); wr(3'd3, 8'hF0, 1);
        push_burst("R7 reseeded prbs", 0); req_pulse(); drain();

        // R10: activate while idle does nothing
        act_pulse();
        @(negedge clk);
        check(!act_err, "R10 idle activate no flag", act_err, 0);

        // R10: activate during a burst is ignored but flagged
        wr(3'd4, 8'h00, 1); wr(3'd0, 8'h81, 1); wr(3'd1, 8'h7E, 1);
        push_burst("R10 burst undisturbed by activate", 0); req_pulse();
        repeat (3) @(posedge clk);
        act_pulse();
        // R11: write during the burst discarded
        wr(3'd0, 8'hFF, 0);
        drain();
        check(act_err, "R10 sticky error flag", act_err, 1);
        push_burst("R11 write during burst discarded", 0); req_pulse(); drain();
        check(act_err, "R10 flag still set", act_err, 1);
        check(q_d.size() == 0, "R1 all expected beats seen", q_d.size(), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule